// File: doc/BRIEF.md
# Single-Wire Slave ROM Command Stage

This block is the network-layer stage of a single-wire slave node. It runs after every bus reset and before any memory command. A bit-level link engine passes it three things: a strobe when a reset pulse is seen, each command byte it assembles, and a strobe at the end of every time slot together with the sampled line value. The block decodes the one ROM command that follows each reset. Depending on that command, it sends its identity, compares the identity the master sends, takes part in a search, or is selected without any identity. It then either hands the bus to the memory-function layer or stays silent until the next reset.

The 64-bit identity is built from two parameters, a family code and a 48-bit serial number. The trailing CRC byte is not stored. A serial CRC-8 register produces it as the identity bits stream past, and the same register supplies the expected bits when the master sends that byte back. Two commands switch the node to the fast signalling speed. Only a reset flagged as long by the link engine returns the node to standard speed.

Top module: `owid_rom_layer`

## Requirements
- R1: After `rst_n` the node is not selected, drives nothing (`tx_en` low), is at standard speed, and ignores command bytes and slot strobes until the first `bus_reset`.
- R2: The identity is sent least-significant bit first. Bits 7:0 are the family code (default 23h), bits 55:8 are the serial number, and bits 63:56 are a CRC-8 over bits 55:0 with polynomial x^8+x^5+x^4+1, shifted LSB first from zero.
- R3: Command 33h makes the node drive its 64 identity bits, one per slot (`tx_en` high, `tx_bit` = identity bit). It is selected on the strobe that ends the 64th slot.
- R4: Command CCh selects the node in the cycle after the byte, with no identity exchanged and the speed unchanged.
- R5: After command 55h the node compares each received slot value with its own identity bit. All 64 equal selects it on the 64th strobe. The first unequal bit deselects it on that strobe.
- R6: Command 3Ch selects the node and sets `od_mode`.
- R7: Command 69h sets `od_mode` at once and then matches as in R5. A full match leaves the node selected at fast speed. A mismatch deselects it and clears `od_mode`. A mismatch after 55h leaves `od_mode` unchanged.
- R8: After command F0h each identity bit takes three slots: the node drives the true bit, then its complement, then reads the master's chosen bit. A chosen bit unequal to its own deselects it. Agreement on all 64 bits selects it.
- R9: Any other command byte deselects the node.
- R10: A deselected node keeps `tx_en` and `mem_sel` low and ignores all bytes and slots until the next `bus_reset`.
- R11: `bus_reset` returns the node to the command stage from any state and clears `mem_sel` in the next cycle. `od_mode` is cleared only if `reset_long` is high with it.
- R12: While selected, the node ignores further bytes and slots (the memory layer owns the bus) and never drives `tx_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous-free synchronous reset |
| bus_reset | input | 1 | One-cycle strobe: reset pulse detected on the wire |
| reset_long | input | 1 | Qualifies `bus_reset` as standard-speed length |
| byte_vld | input | 1 | One-cycle strobe: `rx_byte` holds a received byte |
| rx_byte | input | 8 | Received command byte |
| slot_stb | input | 1 | One-cycle strobe at the end of a time slot |
| slot_bit | input | 1 | Line value sampled in that slot |
| tx_en | output | 1 | Node drives the coming read slot |
| tx_bit | output | 1 | Value to drive when `tx_en` is high, else 0 |
| mem_sel | output | 1 | Node selected; memory layer takes over |
| od_mode | output | 1 | Fast signalling speed active |

## Verification
The bound checker watches, on every cycle, how resets clear selection and speed. It also checks that a deselected node stays silent and sticky, that driving and selection never overlap, and that selection and speed changes only follow a byte or slot strobe. Whether the transmitted bits form the right identity with the right CRC, and whether the complement and search decisions are correct, can only be shown by the bench. The bench compares every output each clock against a behavioural model and checks the collected identity against a CRC it computes itself. It also shows that speed survives a short reset and that only a failed fast-speed match drops it.

// File: rtl/owid_rom_layer.sv
module owid_rom_layer #(
  parameter logic [7:0]  FAMILY = 8'h23,
  parameter logic [47:0] SERIAL = 48'h0000_5A3C_91E7
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bus_reset,
  input  logic       reset_long,
  input  logic       byte_vld,
  input  logic [7:0] rx_byte,
  input  logic       slot_stb,
  input  logic       slot_bit,
  output logic       tx_en,
  output logic       tx_bit,
  output logic       mem_sel,
  output logic       od_mode
);
  localparam logic [63:0] BODY = {8'h00, SERIAL, FAMILY};

  typedef enum logic [2:0] {S_OFF, S_CMD, S_READ, S_MATCH, S_SRCH, S_SEL} st_t;

  st_t        st;
  logic [5:0] idx;
  logic [1:0] ph;
  logic [7:0] crc;
  logic       od, ovm;

  logic       own, fb, last, rx_slot, miss, adv;
  logic [7:0] crc_nx;

  assign own     = (idx < 6'd56) ? BODY[idx] : crc[0];
  assign fb      = crc[0] ^ own;
  assign crc_nx  = {1'b0, crc[7:1]} ^ (fb ? 8'h8C : 8'h00);
  assign last    = &idx;
  assign rx_slot = slot_stb && (st == S_MATCH || (st == S_SRCH && ph == 2'd2));
  assign miss    = rx_slot && (slot_bit != own);
  assign adv     = slot_stb && !miss &&
                   (st == S_READ || st == S_MATCH || (st == S_SRCH && ph == 2'd2));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st  <= S_OFF;
      idx <= '0;
      ph  <= '0;
      crc <= '0;
      od  <= 1'b0;
      ovm <= 1'b0;
    end else if (bus_reset) begin
      st  <= S_CMD;
      idx <= '0;
      ph  <= '0;
      crc <= '0;
      ovm <= 1'b0;
      if (reset_long) od <= 1'b0;
    end else begin
      if (adv) begin
        idx <= idx + 6'd1;
        crc <= crc_nx;
      end
      if (st == S_SRCH && slot_stb)
        ph <= (ph == 2'd2) ? 2'd0 : ph + 2'd1;
      if (miss) begin
        st <= S_OFF;
        if (ovm) od <= 1'b0;
      end else if (adv && last) begin
        st <= S_SEL;
      end
      if (st == S_CMD && byte_vld) begin
        case (rx_byte)
          8'h33:   st <= S_READ;
          8'h55:   st <= S_MATCH;
          8'hF0:   st <= S_SRCH;
          8'hCC:   st <= S_SEL;
          8'h3C: begin
            st <= S_SEL;
            od <= 1'b1;
          end
          8'h69: begin
            st  <= S_MATCH;
            od  <= 1'b1;
            ovm <= 1'b1;
          end
          default: st <= S_OFF;
        endcase
      end
    end
  end

  assign tx_en   = (st == S_READ) || (st == S_SRCH && ph != 2'd2);
  assign tx_bit  = tx_en & (own ^ (st == S_SRCH && ph == 2'd1));
  assign mem_sel = (st == S_SEL);
  assign od_mode = od;
endmodule

// File: rtl/owid_rom_chk.sv
module owid_rom_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       bus_reset,
  input logic       reset_long,
  input logic       byte_vld,
  input logic       slot_stb,
  input logic       mem_sel,
  input logic       od_mode,
  input logic       tx_en,
  input logic [2:0] st_code
);
  logic off;
  assign off = (st_code == 3'd0);

  // R11
  reset_unselects_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_reset |=> !mem_sel);

  // R11
  long_reset_speed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_reset && reset_long) |=> !od_mode);

  // R12
  drive_vs_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(tx_en && mem_sel));

  // R10
  off_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (off && !bus_reset) |=> off);

  // R10
  off_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    off |-> (!tx_en && !mem_sel));

  // R6
  speed_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(od_mode) |-> $past(byte_vld));

  // R4
  select_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_sel) |-> $past(byte_vld || slot_stb));
endmodule

bind owid_rom_layer owid_rom_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bus_reset(bus_reset), .reset_long(reset_long),
  .byte_vld(byte_vld), .slot_stb(slot_stb), .mem_sel(mem_sel),
  .od_mode(od_mode), .tx_en(tx_en), .st_code(st)
);

// File: tb/owid_rom_layer_test.sv
`timescale 1ns/1ps
module owid_rom_layer_test;
  localparam logic [47:0] SER = 48'h0000_5A3C_91E7;

  function automatic logic [63:0] make_id(input logic [55:0] body);
    logic [7:0] c;
    c = 8'h00;
    for (int i = 0; i < 56; i++) begin
      logic f;
      f = c[0] ^ body[i];
      c = {f, c[7:1]};
      c[3] = c[3] ^ f;
      c[2] = c[2] ^ f;
    end
    return {c, body};
  endfunction

  localparam logic [63:0] ID = make_id({SER, 8'h23});

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n = 1'b0, bus_reset = 1'b0, reset_long = 1'b0;
  logic byte_vld = 1'b0, slot_stb = 1'b0, slot_bit = 1'b0;
  logic [7:0] rx_byte = 8'h00;
  logic tx_en, tx_bit, mem_sel, od_mode;

  owid_rom_layer #(.FAMILY(8'h23), .SERIAL(SER)) uut (
    .clk(clk), .rst_n(rst_n), .bus_reset(bus_reset), .reset_long(reset_long),
    .byte_vld(byte_vld), .rx_byte(rx_byte), .slot_stb(slot_stb),
    .slot_bit(slot_bit), .tx_en(tx_en), .tx_bit(tx_bit),
    .mem_sel(mem_sel), .od_mode(od_mode)
  );

  int vectors = 0, fails = 0, edges = 0;
  bit done = 1'b0;
  string req = "R1";

  // behavioural reference: 0 off, 1 cmd, 2 read, 3 match, 4 search, 5 selected
  int ms = 0, pos = 0, mph = 0;
  bit mod = 1'b0, movm = 1'b0;

  always @(posedge clk) begin
    edges <= edges + 1;
    if (!rst_n) begin
      ms = 0; pos = 0; mph = 0; mod = 1'b0; movm = 1'b0;
    end else if (bus_reset) begin
      ms = 1; pos = 0; mph = 0; movm = 1'b0;
      if (reset_long) mod = 1'b0;
    end else begin
      case (ms)
        1: if (byte_vld) begin
          if (rx_byte == 8'h33) ms = 2;
          else if (rx_byte == 8'h55) ms = 3;
          else if (rx_byte == 8'hF0) ms = 4;
          else if (rx_byte == 8'hCC) ms = 5;
          else if (rx_byte == 8'h3C) begin ms = 5; mod = 1'b1; end
          else if (rx_byte == 8'h69) begin ms = 3; mod = 1'b1; movm = 1'b1; end
          else ms = 0;
        end
        2: if (slot_stb) begin
          if (pos == 63) ms = 5; else pos = pos + 1;
        end
        3: if (slot_stb) begin
          if (slot_bit != ID[pos]) begin ms = 0; if (movm) mod = 1'b0; end
          else if (pos == 63) ms = 5;
          else pos = pos + 1;
        end
        4: if (slot_stb) begin
          if (mph < 2) mph = mph + 1;
          else if (slot_bit != ID[pos]) ms = 0;
          else begin
            mph = 0;
            if (pos == 63) ms = 5; else pos = pos + 1;
          end
        end
        default: ;
      endcase
    end
  end

  always @(negedge clk) begin
    if (edges > 0 && !done) begin
      logic es, et, eb;
      es = (ms == 5);
      et = (ms == 2) || (ms == 4 && mph < 2);
      eb = et ? (ID[pos[5:0]] ^ (ms == 4 && mph == 1)) : 1'b0;
      vectors++;
      if ({mem_sel, od_mode, tx_en, tx_bit} !== {es, mod, et, eb}) begin
        fails++;
        $display("FAIL %s: sel/od/tx_en/tx_bit = %b%b%b%b, expected %b%b%b%b",
                 req, mem_sel, od_mode, tx_en, tx_bit, es, mod, et, eb);
      end
    end
  end

  task automatic tick(int n = 1);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic check(string r, logic [63:0] got, logic [63:0] exp);
    vectors++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h, expected %h", r, got, exp);
    end
  endtask

  task automatic wire_reset(bit lng);
    bus_reset = 1'b1; reset_long = lng; tick();
    bus_reset = 1'b0; reset_long = 1'b0; tick();
  endtask

  task automatic send_cmd(logic [7:0] b);
    byte_vld = 1'b1; rx_byte = b; tick();
    byte_vld = 1'b0; tick();
  endtask

  task automatic slot(bit b, output bit seen);
    seen = tx_bit;
    slot_stb = 1'b1; slot_bit = b; tick();
    slot_stb = 1'b0; tick();
  endtask

  task automatic match_id(logic [7:0] cmd, int flip_at);
    bit s;
    send_cmd(cmd);
    for (int i = 0; i < 64; i++) begin
      slot((i == flip_at) ? ~ID[i] : ID[i], s);
      if (i == flip_at) break;
    end
  endtask

  task automatic search_id(int diverge_at, output logic [63:0] got);
    bit t, c, s;
    got = '0;
    send_cmd(8'hF0);
    for (int i = 0; i < 64; i++) begin
      slot(1'b0, t);
      slot(1'b0, c);
      got[i] = t;
      check("R8", {63'd0, c}, {63'd0, ~t});
      slot((i == diverge_at) ? ~t : t, s);
      if (i == diverge_at) break;
    end
  endtask

  initial begin
    logic [63:0] cap;
    bit s;
    tick(3);
    rst_n = 1'b1;
    tick(2);
    req = "R1";
    check("R1", {61'd0, mem_sel, od_mode, tx_en}, 64'd0);
    send_cmd(8'hCC);
    slot(1'b0, s);
    check("R1", {63'd0, mem_sel}, 64'd0);

    wire_reset(1'b1);
    req = "R3";
    send_cmd(8'h33);
    cap = '0;
    for (int i = 0; i < 64; i++) begin slot(1'b0, s); cap[i] = s; end
    check("R3", {63'd0, mem_sel}, 64'd1);
    check("R2", cap, ID);
    check("R2", {56'd0, cap[7:0]}, 64'h23);

    wire_reset(1'b0);
    req = "R4";
    send_cmd(8'hCC);
    check("R4", {62'd0, mem_sel, od_mode}, 64'b10);
    req = "R12";
    send_cmd(8'h33);
    slot(1'b1, s); slot(1'b0, s);
    check("R12", {62'd0, mem_sel, tx_en}, 64'b10);

    wire_reset(1'b0);
    req = "R5";
    match_id(8'h55, -1);
    check("R5", {63'd0, mem_sel}, 64'd1);
    wire_reset(1'b0);
    match_id(8'h55, 60);
    check("R5", {63'd0, mem_sel}, 64'd0);
    req = "R10";
    slot(1'b1, s); send_cmd(8'hCC); slot(1'b0, s);
    check("R10", {62'd0, mem_sel, tx_en}, 64'd0);

    wire_reset(1'b1);
    req = "R6";
    send_cmd(8'h3C);
    check("R6", {62'd0, mem_sel, od_mode}, 64'b11);
    req = "R11";
    wire_reset(1'b0);
    check("R11", {62'd0, mem_sel, od_mode}, 64'b01);
    req = "R7";
    match_id(8'h55, 3);
    check("R7", {62'd0, mem_sel, od_mode}, 64'b01);
    req = "R11";
    wire_reset(1'b1);
    check("R11", {63'd0, od_mode}, 64'd0);

    req = "R7";
    byte_vld = 1'b1; rx_byte = 8'h69; tick();
    byte_vld = 1'b0; tick();
    check("R7", {63'd0, od_mode}, 64'd1);
    for (int i = 0; i < 64; i++) slot(ID[i], s);
    check("R7", {62'd0, mem_sel, od_mode}, 64'b11);
    wire_reset(1'b1);
    match_id(8'h69, 5);
    check("R7", {62'd0, mem_sel, od_mode}, 64'b00);

    wire_reset(1'b1);
    req = "R8";
    search_id(-1, cap);
    check("R8", {63'd0, mem_sel}, 64'd1);
    check("R8", cap, ID);
    wire_reset(1'b0);
    search_id(20, cap);
    check("R8", {62'd0, mem_sel, tx_en}, 64'd0);

    wire_reset(1'b0);
    req = "R9";
    send_cmd(8'hA5);
    send_cmd(8'h33);
    slot(1'b0, s);
    check("R9", {62'd0, mem_sel, tx_en}, 64'd0);

    wire_reset(1'b0);
    req = "R11";
    send_cmd(8'h33);
    for (int i = 0; i < 10; i++) slot(1'b0, s);
    wire_reset(1'b0);
    check("R11", {62'd0, mem_sel, tx_en}, 64'd0);
    send_cmd(8'hCC);
    check("R11", {63'd0, mem_sel}, 64'd1);

    tick(2);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      fails++;
      $display("FAIL watchdog: run did not complete, got timeout, expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end
endmodule